// File: doc/BRIEF.md
# Windowed Serial Signature Analyzer

The block folds one serial test-node bit stream into a 16-bit signature. A window opens on a chosen edge of `start_i` and closes on a chosen edge of `stop_i`. While the window is open, each sampled bit of `data_i` is shifted through a linear feedback shift register. The feedback XOR taps of that register divide the stream by a generator polynomial. The window is cleared at every opening, so repeated runs over the same stimulus give the same signature.

When the window closes, the signature stops changing. It is compared with a reference word held in an internal register, which is written through `ref_i`/`ref_we_i`. A one-cycle done pulse marks the close. A pass or a fail flag then stays up until the next window opens.

`start_i` and `stop_i` are synchronized and edge-detected on the block clock. `data_i` goes through a pipeline of equal depth, so the window boundaries and the data stay aligned. A parameter selects whether `data_i` is captured on the falling or the rising clock edge. The falling edge gives the measured node half a period to settle.

Top module: `sig_window_analyzer`

## Requirements
- R1: While `rst_ni` is low, `sig_o`, `win_o`, `done_o`, `pass_o` and `fail_o` are all 0.
- R2: `start_rise_i`=1 makes a rising edge of `start_i` the opening event, and `start_rise_i`=0 makes a falling edge the opening event. Say the opening edge is first sampled at rising clock edge k. After edge k+2, `sig_o`=0, `win_o`=1, and `pass_o` and `fail_o` are both 0.
- R3: `stop_rise_i` selects the closing edge of `stop_i` in the same way. While the window is open, a closing edge first sampled at clock edge k drops `win_o` after edge k+2. `sig_o` then holds its value until the next opening event.
- R4: With `SAMPLE_FALL`=0, the bits taken are the values of `data_i` at the rising edges that lie strictly between the edge that first samples the opening change and the edge that first samples the closing change. They are taken in order. Each bit b updates the signature s to ({s[14:0],b}) XOR (s[15] ? 16'h1281 : 0). This is division by x^16+x^12+x^9+x^7+1. The polynomial is a parameter.
- R5: With `SAMPLE_FALL`=1, each bit that R4 would take at a rising edge is taken instead from the falling clock edge that follows that rising edge.
- R6: At the closing edge of R3, `pass_o`=1 and `fail_o`=0 if the signature equals the reference register. Otherwise `pass_o`=0 and `fail_o`=1. Both flags hold until the next opening event.
- R7: The reference register takes `ref_i` at each rising edge where `ref_we_i`=1. It keeps its value at every other edge.
- R8: Edges of the unselected polarity on `start_i` or `stop_i` have no effect. A closing edge while the window is closed produces no done pulse and leaves `sig_o`, `pass_o` and `fail_o` unchanged.
- R9: An opening event while the window is already open restarts the run. The signature returns to 0, and only the bits after the new opening edge count.
- R10: `done_o` is high for exactly one clock, in the cycle where `win_o` first reads 0 after a close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 1 | Serial test-node bit |
| start_i | input | 1 | Window opening line |
| stop_i | input | 1 | Window closing line |
| start_rise_i | input | 1 | 1: open on rising edge of start_i, 0: on falling edge |
| stop_rise_i | input | 1 | 1: close on rising edge of stop_i, 0: on falling edge |
| ref_i | input | SIG_W | Reference signature write data |
| ref_we_i | input | 1 | Reference write enable |
| sig_o | output | SIG_W | Current or frozen signature |
| win_o | output | 1 | Window open |
| done_o | output | 1 | One-cycle pulse at window close |
| pass_o | output | 1 | Signature matched reference |
| fail_o | output | 1 | Signature differed from reference |

## Verification
Suppose the pipeline that carries `data_i` falls out of step with the start and stop synchronizers by one stage. The window then gains or loses a bit at one end, and the wrong signature is visible at `sig_o` and in the pass/fail flags three cycles after the closing change. The bench sweeps window lengths from 0 to 40 bits under all four polarity pairs, so an error in the divider taps shows up within the first windows long enough to bring a 1 into the top bit. A signature that moves while the window is closed, or a done flag that stays up, is seen within one cycle of the close, because the bench samples every cycle around it.

// File: rtl/sig_an_pkg.sv
package sig_an_pkg;
  localparam int unsigned SIG_W_DEF     = 16;
  localparam logic [15:0] SIG_POLY_DEF  = 16'h1281; // x^16+x^12+x^9+x^7+1, x^16 implied
  localparam int unsigned SYNC_DEF      = 2;
endpackage

// File: rtl/sig_edge_sync.sv
module sig_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic rise_sel_i,
  output logic event_o
);
  logic [STAGES:0] chain_q;
  logic cur, prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-1:0], line_i};
  end

  assign cur     = chain_q[STAGES-1];
  assign prev    = chain_q[STAGES];
  assign event_o = rise_sel_i ? (cur & ~prev) : (~cur & prev);

  // an edge cannot be seen on two consecutive cycles
  assert_event_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |=> !event_o);
endmodule

// File: rtl/sig_sample_pipe.sv
module sig_sample_pipe #(
  parameter int unsigned STAGES      = 2,
  parameter bit          SAMPLE_FALL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  output logic data_o
);
  logic [STAGES-1:0] pipe_q;

  // first stage picks the sampling edge, the rest retime to rising edges
  if (SAMPLE_FALL) begin : g_fall
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[0] <= 1'b0;
      else         pipe_q[0] <= data_i;
    end
  end else begin : g_rise
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[0] <= 1'b0;
      else         pipe_q[0] <= data_i;
    end
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[i] <= 1'b0;
      else         pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign data_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sig_lfsr.sv
module sig_lfsr #(
  parameter int unsigned   W    = 16,
  parameter logic [W-1:0]  POLY = 16'h1281
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] st_q, nxt;
  logic         fb;

  assign fb = st_q[W-1];

  // internal-XOR divider: shift in at bit 0, subtract divisor when top bit falls out
  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == 0) begin : g_lsb
      assign nxt[i] = bit_i ^ (POLY[i] & fb);
    end else begin : g_mid
      assign nxt[i] = st_q[i-1] ^ (POLY[i] & fb);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= '0;
    else if (clr_i) st_q <= '0;
    else if (en_i)  st_q <= nxt;
  end

  assign state_o = st_q;

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(st_q));
  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (st_q == '0));
endmodule

// File: rtl/sig_window_analyzer.sv
module sig_window_analyzer
  import sig_an_pkg::*;
#(
  parameter int unsigned      SIG_W       = SIG_W_DEF,
  parameter logic [SIG_W-1:0] POLY        = SIG_POLY_DEF,
  parameter int unsigned      SYNC_STAGES = SYNC_DEF,
  parameter bit               SAMPLE_FALL = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             start_rise_i,
  input  logic             stop_rise_i,
  input  logic [SIG_W-1:0] ref_i,
  input  logic             ref_we_i,
  output logic [SIG_W-1:0] sig_o,
  output logic             win_o,
  output logic             done_o,
  output logic             pass_o,
  output logic             fail_o
);
  logic             start_ev, stop_ev, data_s;
  logic             win_q, done_q, pass_q, fail_q;
  logic [SIG_W-1:0] ref_q, sig;
  logic             shift_en, match, close_ev;

  sig_edge_sync #(.STAGES(SYNC_STAGES)) u_start (
    .clk_i, .rst_ni, .line_i(start_i), .rise_sel_i(start_rise_i), .event_o(start_ev));

  sig_edge_sync #(.STAGES(SYNC_STAGES)) u_stop (
    .clk_i, .rst_ni, .line_i(stop_i), .rise_sel_i(stop_rise_i), .event_o(stop_ev));

  // same depth as the synchronizers keeps data aligned with window edges
  sig_sample_pipe #(.STAGES(SYNC_STAGES), .SAMPLE_FALL(SAMPLE_FALL)) u_data (
    .clk_i, .rst_ni, .data_i, .data_o(data_s));

  assign close_ev = win_q & stop_ev & ~start_ev;
  assign shift_en = win_q & ~stop_ev & ~start_ev;

  sig_lfsr #(.W(SIG_W), .POLY(POLY)) u_lfsr (
    .clk_i, .rst_ni, .clr_i(start_ev), .en_i(shift_en), .bit_i(data_s), .state_o(sig));

  assign match = (sig == ref_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= '0;
    else if (ref_we_i) ref_q <= ref_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= 1'b0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_ev) begin
        win_q  <= 1'b1;
        pass_q <= 1'b0;
        fail_q <= 1'b0;
      end else if (close_ev) begin
        win_q  <= 1'b0;
        done_q <= 1'b1;
        pass_q <= match;
        fail_q <= ~match;
      end
    end
  end

  assign sig_o  = sig;
  assign win_o  = win_q;
  assign done_o = done_q;
  assign pass_o = pass_q;
  assign fail_o = fail_q;

  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_closed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !win_o);
  assert_verdict_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pass_o ^ fail_o));
  assert_open_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ev |=> (sig_o == '0 && win_o && !pass_o && !fail_o));
  assert_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_o && !start_ev) |=> $stable(sig_o));
  assert_stray_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_ev && !win_o && !start_ev) |=> (!done_o && $stable(pass_o) && $stable(fail_o)));
endmodule

// File: tb/sim_sig_window_analyzer.sv
module sim_sig_window_analyzer;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        data_i, start_i, stop_i, start_rise_i, stop_rise_i;
  logic [15:0] ref0_i, ref1_i;
  logic        ref_we_i;
  logic [15:0] sig0, sig1;
  logic        win0, done0, pass0, fail0;
  logic        win1, done1, pass1, fail1;

  int checks = 0;
  int failures = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #(CLK_P/2) clk_i = ~clk_i;

  sig_window_analyzer u0 (
    .clk_i, .rst_ni, .data_i, .start_i, .stop_i, .start_rise_i, .stop_rise_i,
    .ref_i(ref0_i), .ref_we_i, .sig_o(sig0), .win_o(win0), .done_o(done0),
    .pass_o(pass0), .fail_o(fail0));

  sig_window_analyzer #(.SAMPLE_FALL(1'b1)) u1 (
    .clk_i, .rst_ni, .data_i, .start_i, .stop_i, .start_rise_i, .stop_rise_i,
    .ref_i(ref1_i), .ref_we_i, .sig_o(sig1), .win_o(win1), .done_o(done1),
    .pass_o(pass1), .fail_o(fail1));

  function automatic logic [15:0] step(logic [15:0] s, logic b);
    return {s[14:0], b} ^ (s[15] ? 16'h1281 : 16'h0000);
  endfunction

  function automatic logic rnd_bit();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[16];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic settle(input bit sp, input bit pp);
    start_rise_i = sp; stop_rise_i = pp;
    start_i = ~sp;     stop_i = ~pp;
    repeat (4) tick();
  endtask

  // c0 drives the opening edge; bits c1..cn; closing edge with cn+1
  task automatic run_window(input int n, input bit sp, input bit pp, input bit bad);
    logic dv [0:63];
    logic [15:0] e0, e1, flip, held;
    for (int k = 0; k < 64; k++) dv[k] = rnd_bit();
    e0 = '0; for (int k = 1; k <= n; k++)     e0 = step(e0, dv[k]);
    e1 = '0; for (int k = 2; k <= n + 1; k++) e1 = step(e1, dv[k]);
    flip = bad ? (16'h0001 << (n % 16)) : 16'h0000;
    settle(sp, pp);
    #3;
    chk(win0 == 1'b0, "R8 inactive edge kept window shut", {31'd0, win0}, 32'd0);
    ref0_i = e0 ^ flip; ref1_i = e1 ^ flip; ref_we_i = 1'b1;
    tick();
    ref_we_i = 1'b0; ref0_i = ~ref0_i; ref1_i = ~ref1_i; // R7 not written
    start_i = sp; data_i = dv[0];
    tick();
    for (int k = 1; k <= n + 4; k++) begin
      data_i = dv[k];
      if (k == 1)     start_i = ~sp;
      if (k == n + 1) stop_i  = pp;
      if (k == n + 2) stop_i  = ~pp;
      #3;
      if (k == 3) begin
        chk(win0 == 1'b1, "R2 window open", {31'd0, win0}, 32'd1);
        chk(sig0 == 16'h0, "R2 cleared", {16'd0, sig0}, 32'd0);
        chk(!pass0 && !fail0, "R2 flags cleared", {30'd0, pass0, fail0}, 32'd0);
      end
      if (k == n + 3)
        chk(done0 == 1'b0 && win0 == 1'b1, "R3 close not early", {30'd0, done0, win0}, 32'd1);
      if (k == n + 4) begin
        chk(sig0 == e0, "R4 signature", {16'd0, sig0}, {16'd0, e0});
        chk(sig1 == e1, "R5 falling-edge signature", {16'd0, sig1}, {16'd0, e1});
        chk(done0 == 1'b1 && win0 == 1'b0, "R10 done at close", {30'd0, done0, win0}, 32'd2);
        chk(pass0 == !bad && fail0 == bad, "R6 R7 verdict", {30'd0, pass0, fail0}, {30'd0, !bad, bad});
        chk(pass1 == !bad && fail1 == bad, "R6 verdict falling", {30'd0, pass1, fail1}, {30'd0, !bad, bad});
      end
      tick();
    end
    held = sig0;
    for (int k = 0; k < 3; k++) begin
      data_i = ~data_i;
      #3;
      chk(done0 == 1'b0, "R10 single pulse", {31'd0, done0}, 32'd0);
      chk(sig0 == held && pass0 == !bad, "R3 frozen", {16'd0, sig0}, {16'd0, held});
      tick();
    end
  endtask

  initial begin
    rst_ni = 1'b0; data_i = 1'b0; start_i = 1'b0; stop_i = 1'b0;
    start_rise_i = 1'b1; stop_rise_i = 1'b1;
    ref0_i = '0; ref1_i = '0; ref_we_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    chk(sig0 == 16'h0 && !win0 && !done0 && !pass0 && !fail0, "R1 reset",
        {16'd0, sig0}, 32'd0);
    rst_ni = 1'b1;
    tick();

    for (int n = 0; n <= 40; n++)
      for (int p = 0; p < 4; p++)
        run_window(n, p[1], p[0], (n % 3) == 1);

    // R9 restart while open
    begin
      logic dv [0:19];
      logic [15:0] e0, e1;
      for (int k = 0; k < 20; k++) dv[k] = rnd_bit();
      e0 = '0; for (int k = 6; k <= 13; k++) e0 = step(e0, dv[k]);
      e1 = '0; for (int k = 7; k <= 14; k++) e1 = step(e1, dv[k]);
      settle(1'b1, 1'b1);
      for (int k = 0; k <= 18; k++) begin
        data_i = dv[k];
        start_i = (k == 0 || k == 5);
        stop_i  = (k == 14);
        #3;
        if (k == 8) chk(sig0 == 16'h0 && win0, "R9 restart clears", {16'd0, sig0}, 32'd0);
        if (k == 17) begin
          chk(sig0 == e0, "R9 restart signature", {16'd0, sig0}, {16'd0, e0});
          chk(sig1 == e1, "R9 R5 restart falling", {16'd0, sig1}, {16'd0, e1});
          chk(done0 == 1'b1, "R9 done", {31'd0, done0}, 32'd1);
        end
        tick();
      end
    end

    // R8 closing edge with window shut
    begin
      logic [15:0] held;
      logic hp, hf;
      held = sig0; hp = pass0; hf = fail0;
      for (int k = 0; k < 7; k++) begin
        stop_i = (k == 0);
        data_i = rnd_bit();
        #3;
        chk(!done0 && !win0, "R8 stray stop no done", {30'd0, done0, win0}, 32'd0);
        chk(sig0 == held && pass0 == hp && fail0 == hf, "R8 stray stop no change",
            {16'd0, sig0}, {16'd0, held});
        tick();
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule